// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block keeps a page-mode DRAM alive. After reset it stays quiet for a programmable settling pause. It then runs a fixed number of back-to-back refresh cycles without asking anyone, and reports that the memory is ready. From that point an interval timer adds one owed refresh each period. Each refresh is a CAS-before-RAS cycle, so the part's own row counter chooses the row and no address is driven. The sequencer asks the access controller for the bus through a request/grant pair. Once granted, it drives the row and column strobes itself for the whole cycle and holds a busy flag so the controller keeps off the bus.

Owed refreshes can pile up to a small limit while the controller is occupied with a burst. When the controller later holds grant, the backlog is served back-to-back. A tick that arrives while the backlog is already full raises a sticky overflow flag. A level request puts the memory into self-refresh: the strobes are held low for at least a minimum time, then released with a recovery gap. The interval timer is frozen for as long as the memory refreshes itself.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is applied: `ras_n` is 1, every `cas_n` lane is 1, `busy` is 1, and `ref_req`, `init_done`, `sr_active` and `overflow` are 0.
- R2: After reset is released, the strobes stay high for at least `INIT_PAUSE` cycles. Then exactly `WAKE_CYCLES` refresh cycles run without a grant. Between two of these cycles both strobes are high for exactly `T_RP` cycles. `ref_req` stays 0 until `init_done` rises, and `init_done` rises after the last of these cycles.
- R3: In every refresh cycle all `cas_n` lanes move together. CAS is low for `T_CSR` cycles before RAS falls and stays low for `T_CHR` cycles after RAS falls. RAS stays low for `T_RAS` cycles in total.
- R4: After RAS rises, both strobes stay high for at least `T_RP` cycles before CAS falls again.
- R5: Once `init_done` is 1, one refresh becomes owed every `REF_INTERVAL` cycles. `ref_req` is 1 exactly while the sequencer is idle and a refresh is owed or self-refresh is requested.
- R6: A refresh cycle starts only in the cycle after `ref_req` and `grant` were both 1. From that cycle `busy` is 1 until the precharge or recovery ends. With `grant` at 0, no strobe moves.
- R7: Owed refreshes accumulate up to `OWED_MAX`. While `grant` is held, they are served back-to-back, one cycle each, and `ref_req` then falls.
- R8: An interval tick that arrives with `OWED_MAX` refreshes already owed sets `overflow`. The flag stays set until reset, and the owed count stays at `OWED_MAX`.
- R9: When `sr_req` is 1 at a grant, the sequencer runs the CAS-before-RAS entry and then holds RAS and CAS low, with `sr_active` at 1, while `sr_req` stays 1. RAS is low for no fewer than `T_RASS` cycles, and for exactly `T_RASS` when `sr_req` drops early.
- R10: After self-refresh ends, RAS and CAS rise together, and `busy` stays 1 for exactly `T_RPS` cycles with RAS high.
- R11: No refresh becomes owed during self-refresh or its recovery. The interval timer resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant | input | 1 | Access controller hands the DRAM bus to the sequencer |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_req | output | 1 | Sequencer wants the bus (refresh owed or self-refresh requested) |
| busy | output | 1 | Sequencer owns the strobes; access controller must wait |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes for all byte lanes, active low, driven together |
| init_done | output | 1 | Wake-up pause and dummy refreshes complete |
| sr_active | output | 1 | Memory is being held in self-refresh |
| overflow | output | 1 | Sticky: an owed refresh was lost because the backlog was full |

## Verification
The strobe shape is measured on every cycle the bench observes. This includes the wake-up burst, a single granted refresh and a backlog served back-to-back, so a timing fault in either the unsolicited path or the granted path shows up. The backlog is tried twice: once with ticks that stay just inside the limit, and once with ticks past it. These two runs separate plain accumulation from saturation with the sticky flag. Self-refresh is held once for longer than several refresh intervals and once released at the earliest moment. The long hold shows that the interval timer is frozen. The short hold pins the minimum RAS-low time exactly.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CAS_SETUP,
    ST_RAS_LOW,
    ST_CAS_REL,
    ST_PRECHARGE,
    ST_SELF,
    ST_SELF_EXIT
  } rfsh_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned REF_INTERVAL = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == TW'(REF_INTERVAL - 1));
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
  parameter int unsigned OWED_MAX = 8,
  localparam int unsigned OW = $clog2(OWED_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] owed,
  output logic          overflow
);
  logic [OW-1:0] owed_d;
  logic          ovf_d;

  always_comb begin
    owed_d = owed;
    ovf_d  = overflow;
    unique case ({inc, dec})
      2'b10: begin
        if (owed == OW'(OWED_MAX)) ovf_d = 1'b1;
        else                       owed_d = owed + OW'(1);
      end
      2'b01:   owed_d = owed - OW'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed     <= '0;
      overflow <= 1'b0;
    end else begin
      owed     <= owed_d;
      overflow <= ovf_d;
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CAS_LANES    = 4,
  parameter int unsigned INIT_PAUSE   = 50_000_000,
  parameter int unsigned WAKE_CYCLES  = 8,
  parameter int unsigned REF_INTERVAL = 3900,
  parameter int unsigned OWED_MAX     = 8,
  parameter int unsigned T_CSR        = 3,
  parameter int unsigned T_CHR        = 3,
  parameter int unsigned T_RAS        = 13,
  parameter int unsigned T_RP         = 14,
  parameter int unsigned T_RASS       = 25_000,
  parameter int unsigned T_RPS        = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant,
  input  logic                 sr_req,
  output logic                 ref_req,
  output logic                 busy,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n,
  output logic                 init_done,
  output logic                 sr_active,
  output logic                 overflow
);
  localparam int unsigned MAXD = max2(max2(max2(INIT_PAUSE, T_RASS), max2(T_RAS, T_RP)),
                                      max2(max2(T_CSR, T_CHR), T_RPS));
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam int unsigned WW   = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam int unsigned OW   = $clog2(OWED_MAX + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  rfsh_state_t   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          sr_mode_q, sr_mode_d;
  logic          init_q, init_d;
  logic          ras_q, ras_d, cas_q, cas_d;
  logic          tick, start_ref;
  logic [OW-1:0] owed;

  rfsh_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync),
    .en    (init_q && !sr_mode_q),
    .tick  (tick)
  );

  rfsh_debt_counter #(.OWED_MAX(OWED_MAX)) u_debt (
    .clk      (clk),
    .rst_n    (rst_sync),
    .inc      (tick),
    .dec      (start_ref),
    .owed     (owed),
    .overflow (overflow)
  );

  function automatic logic [CW-1:0] phase_len(input rfsh_state_t s);
    case (s)
      ST_PAUSE:     return CW'(INIT_PAUSE - 1);
      ST_CAS_SETUP: return CW'(T_CSR - 1);
      ST_RAS_LOW:   return CW'(T_CHR - 1);
      ST_CAS_REL:   return CW'(T_RAS - T_CHR - 1);
      ST_PRECHARGE: return CW'(T_RP - 1);
      ST_SELF:      return CW'(T_RASS - T_CHR - 1);
      ST_SELF_EXIT: return CW'(T_RPS - 1);
      default:      return '0;
    endcase
  endfunction

  assign ref_req   = (state_q == ST_IDLE) && init_q && ((owed != '0) || sr_req);
  assign busy      = (state_q != ST_IDLE);
  assign sr_active = (state_q == ST_SELF);
  assign ras_n     = ras_q;
  assign cas_n     = {CAS_LANES{cas_q}};
  assign init_done = init_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = (cnt_q != '0) ? cnt_q - CW'(1) : '0;
    wake_d    = wake_q;
    sr_mode_d = sr_mode_q;
    init_d    = init_q;
    start_ref = 1'b0;
    unique case (state_q)
      ST_PAUSE:     if (cnt_q == '0) state_d = ST_CAS_SETUP;
      ST_IDLE: begin
        if (ref_req && grant) begin
          state_d   = ST_CAS_SETUP;
          sr_mode_d = sr_req;
          start_ref = !sr_req;
        end
      end
      ST_CAS_SETUP: if (cnt_q == '0) state_d = ST_RAS_LOW;
      ST_RAS_LOW:   if (cnt_q == '0) state_d = sr_mode_q ? ST_SELF : ST_CAS_REL;
      ST_CAS_REL:   if (cnt_q == '0) state_d = ST_PRECHARGE;
      ST_PRECHARGE: begin
        if (cnt_q == '0) begin
          if (init_q) begin
            state_d = ST_IDLE;
          end else if (wake_q == WW'(WAKE_CYCLES - 1)) begin
            init_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            wake_d  = wake_q + WW'(1);
            state_d = ST_CAS_SETUP;
          end
        end
      end
      ST_SELF:      if ((cnt_q == '0) && !sr_req) state_d = ST_SELF_EXIT;
      ST_SELF_EXIT: begin
        if (cnt_q == '0) begin
          state_d   = ST_IDLE;
          sr_mode_d = 1'b0;
        end
      end
      default:      state_d = ST_IDLE;
    endcase
    if (state_d != state_q) cnt_d = phase_len(state_d);
    ras_d = !((state_d == ST_RAS_LOW) || (state_d == ST_CAS_REL) || (state_d == ST_SELF));
    cas_d = !((state_d == ST_CAS_SETUP) || (state_d == ST_RAS_LOW) || (state_d == ST_SELF));
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q   <= ST_PAUSE;
      cnt_q     <= CW'(INIT_PAUSE - 1);
      wake_q    <= '0;
      sr_mode_q <= 1'b0;
      init_q    <= 1'b0;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      wake_q    <= wake_d;
      sr_mode_q <= sr_mode_d;
      init_q    <= init_d;
      ras_q     <= ras_d;
      cas_q     <= cas_d;
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grant,
  input logic             ref_req,
  input logic             busy,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             init_done,
  input logic             sr_active,
  input logic             overflow
);
  AST_CAS_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n == '0) || (cas_n == '1)); // R3
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (cas_n == '0) && ($past(cas_n) == '0)); // R3
  AST_CAS_FALLS_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> ras_n); // R4
  AST_NO_REQ_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req); // R2
  AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !busy); // R5
  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_req && grant)); // R6
  AST_STROBES_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || (cas_n != '1)) |-> busy); // R6
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_SELF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ras_n && (cas_n == '0)); // R9
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.LANES(CAS_LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant     (grant),
  .ref_req   (ref_req),
  .busy      (busy),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .init_done (init_done),
  .sr_active (sr_active),
  .overflow  (overflow)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
  localparam int P_PAUSE = 20, P_WAKE = 8, P_CSR = 2, P_CHR = 2, P_RAS = 5;
  localparam int P_RP = 3, P_RASS = 10, P_RPS = 4, P_INT = 60, P_OWED = 3;

  logic clk = 1'b0;
  logic rst_n, grant, sr_req;
  logic ref_req, busy, ras_n, init_done, sr_active, overflow;
  logic [3:0] cas_n;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .CAS_LANES(4), .INIT_PAUSE(P_PAUSE), .WAKE_CYCLES(P_WAKE), .REF_INTERVAL(P_INT),
    .OWED_MAX(P_OWED), .T_CSR(P_CSR), .T_CHR(P_CHR), .T_RAS(P_RAS), .T_RP(P_RP),
    .T_RASS(P_RASS), .T_RPS(P_RPS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .sr_req(sr_req), .ref_req(ref_req),
    .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done),
    .sr_active(sr_active), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  // strobe monitor
  int ras_falls = 0, last_csr = 0, last_ras = 0, last_chr = 0;
  int csr_run = 0, ras_run = 0, chr_run = 0, gap_run = 0;
  int min_gap = 1000000, max_gap = 0, lane_err = 0, early_req = 0;
  bit chr_open = 0, had_rise = 0, prev_ras = 1, prev_cas = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!(cas_n == 4'h0 || cas_n == 4'hF)) lane_err++;
      if (!init_done && ref_req) early_req++;
      if (ras_n) begin
        if (!prev_ras) begin
          last_ras = ras_run; last_chr = chr_run; gap_run = 0; had_rise = 1;
        end
        if (!cas_n[0]) begin
          if (prev_cas && had_rise) begin
            if (gap_run < min_gap) min_gap = gap_run;
            if (gap_run > max_gap) max_gap = gap_run;
            had_rise = 0;
          end
          csr_run++;
        end else begin
          csr_run = 0; gap_run++;
        end
      end else begin
        if (prev_ras) begin
          ras_falls++; last_csr = csr_run; csr_run = 0;
          ras_run = 0; chr_run = 0; chr_open = 1;
        end
        ras_run++;
        if (chr_open && !cas_n[0]) chr_run++; else chr_open = 0;
      end
      prev_ras = ras_n; prev_cas = cas_n[0];
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_for_req();
    for (int i = 0; i < 4 * P_INT && !ref_req; i++) step();
  endtask

  task automatic serve(output int served);
    int f0 = ras_falls;
    grant = 1'b1;
    step();
    for (int i = 0; i < 500 && (ref_req || busy); i++) step();
    grant = 1'b0;
    served = ras_falls - f0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant = 1'b0; sr_req = 1'b0;
    repeat (3) step();
    chk(ras_n && cas_n == 4'hF, "R1 strobes", {ras_n, cas_n}, 5'h1F);
    chk(busy && !ref_req && !init_done, "R1 busy/req/init", {busy, ref_req, init_done}, 3'b100);
    chk(!sr_active && !overflow, "R1 sr/ovf", {sr_active, overflow}, 0);
  endtask

  task automatic t_init();
    int pause = 0;
    rst_n = 1'b1;
    step();
    while (cas_n == 4'hF && ras_n && pause < 10 * P_PAUSE) begin pause++; step(); end
    chk(pause >= P_PAUSE && pause <= P_PAUSE + 4, "R2 pause", pause, P_PAUSE);
    for (int i = 0; i < 2000 && !init_done; i++) step();
    chk(init_done && !busy, "R2 init_done", {init_done, busy}, 2'b10);
    chk(ras_falls == P_WAKE, "R2 wake count", ras_falls, P_WAKE);
    chk(min_gap == P_RP && max_gap == P_RP, "R2 wake gap", max_gap, P_RP);
    chk(early_req == 0, "R2 req before init", early_req, 0);
    chk(last_csr == P_CSR, "R3 cas setup", last_csr, P_CSR);
    chk(last_chr == P_CHR, "R3 cas hold", last_chr, P_CHR);
    chk(last_ras == P_RAS, "R3 ras width", last_ras, P_RAS);
  endtask

  task automatic t_interval();
    int n = 0, f0 = ras_falls;
    while (!ref_req && n < 4 * P_INT) begin n++; step(); end
    chk(n >= P_INT - 2 && n <= P_INT + 1, "R5 first interval", n, P_INT);
    chk(ras_falls == f0, "R6 no strobe without grant", ras_falls - f0, 0);
  endtask

  task automatic t_grant();
    int f0 = ras_falls;
    repeat (10) step();
    chk(ref_req && !busy && ras_falls == f0, "R6 waits for grant", ras_falls - f0, 0);
    grant = 1'b1;
    step();
    chk(busy, "R6 busy after grant", busy, 1);
    grant = 1'b0;
    for (int i = 0; i < 100 && busy; i++) step();
    chk(ras_falls == f0 + 1, "R6 one cycle", ras_falls - f0, 1);
    chk(!ref_req, "R5 request cleared", ref_req, 0);
    chk(last_csr == P_CSR && last_chr == P_CHR && last_ras == P_RAS, "R3 granted shape",
        last_ras, P_RAS);
  endtask

  task automatic t_debt();
    int served;
    wait_for_req();
    repeat (125) step();
    chk(ref_req && !overflow, "R7 backlog pending", {ref_req, overflow}, 2'b10);
    min_gap = 1000000;
    serve(served);
    chk(served == 3, "R7 backlog served", served, 3);
    chk(min_gap >= P_RP, "R4 precharge gap", min_gap, P_RP);
    chk(!overflow, "R8 no overflow at limit", overflow, 0);
  endtask

  task automatic t_self_long();
    int bad = 0, exitn = 0;
    sr_req = 1'b1;
    step();
    chk(ref_req, "R9 sr request", ref_req, 1);
    grant = 1'b1;
    step();
    grant = 1'b0;
    for (int i = 0; i < 50 && !sr_active; i++) step();
    for (int i = 0; i < 3 * P_INT; i++) begin
      if (!sr_active || ras_n || cas_n != 4'h0) bad++;
      step();
    end
    chk(bad == 0, "R9 held in self-refresh", bad, 0);
    sr_req = 1'b0;
    step();
    while (busy && exitn < 100) begin
      if (ras_n && cas_n == 4'hF) exitn++;
      step();
    end
    chk(exitn == P_RPS, "R10 recovery", exitn, P_RPS);
    chk(last_ras >= 3 * P_INT, "R9 long ras low", last_ras, 3 * P_INT);
    chk(!ref_req, "R11 nothing owed after self", ref_req, 0);
    exitn = 0;
    while (!ref_req && exitn < 4 * P_INT) begin exitn++; step(); end
    chk(ref_req && exitn < P_INT, "R11 timer resumes", exitn, P_INT);
  endtask

  task automatic t_self_short();
    sr_req = 1'b1; grant = 1'b1;
    step();
    grant = 1'b0;
    for (int i = 0; i < 50 && !sr_active; i++) step();
    sr_req = 1'b0;
    for (int i = 0; i < 100 && busy; i++) step();
    chk(last_ras == P_RASS, "R9 minimum self hold", last_ras, P_RASS);
  endtask

  task automatic t_overflow();
    int served;
    serve(served);
    wait_for_req();
    repeat (170) step();
    chk(!overflow, "R8 no overflow before extra tick", overflow, 0);
    repeat (75) step();
    chk(overflow, "R8 overflow set", overflow, 1);
    serve(served);
    chk(served == P_OWED, "R8 saturated backlog", served, P_OWED);
    chk(overflow, "R8 overflow sticky", overflow, 1);
    chk(lane_err == 0, "R3 lanes together", lane_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_interval();
    t_grant();
    t_debt();
    t_self_long();
    t_self_short();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule